// File: doc/BRIEF.md
# Vectored Interrupt Request Peripheral

This block is a small bus slave that captures incoming data words and asks a processor for service through a vectored interrupt handshake. A capture strobe loads the input word into a holding register and raises a request line. The processor acknowledges with a strobe. While that strobe is high and a request is pending, the peripheral places its own service vector on the read-data bus, so the processor can jump straight to the matching routine. The request stays up until the processor reads the holding register. The service routine can also leave a word in a writable result register, which the block presents on a side output.

A mode input chooses what goes on the bus during acknowledge. In full-address mode the block drives a complete routine address, which is 16 by default. In table mode it drives a short index, 3 by default, into a dispatch table of at most 256 entries. A new capture that arrives while a request is still outstanding replaces the held word and sets a sticky overrun flag.

Top module: `vec_irq_periph`

## Requirements
- R1: A capture strobe (`inValid` high at a rising edge) loads `inData` into the holding register, and `intReq` is high from the following cycle.
- R2: With `tableMode`=0, in any cycle where `intAck` is high and `intReq` is high, `busDoutEn` is 1 and `busDout` equals the full vector, 16 by default, in that same cycle.
- R3: Once raised, `intReq` stays high through acknowledge cycles and all other traffic. It drops after the first rising edge at which the holding register is read, unless a new capture occurs at that same edge.
- R4: A read (`busRd`) of address 0x8000 returns the holding register on `busDout` in the same cycle. A write to 0x8000 has no effect.
- R5: A write (`busWr`) to address 0x8001 loads `busWrData` into the result register. The register reads back at 0x8001 and appears on `resultData` from the next cycle.
- R6: With `tableMode`=1, an acknowledge while a request is pending drives the table index (3 by default, 8-bit index, zero-extended into the low bits) instead of the full vector.
- R7: `busDoutEn` is 1 only during a pending acknowledge or a read of 0x8000 or 0x8001. Whenever it is 0, `busDout` is all zeros, and accesses to any other address change no state.
- R8: A capture while `intReq` is high, with no read of 0x8000 at that edge, sets `overrun` and overwrites the held word with the newer one. A read of 0x8000 clears `overrun`. A capture at the same edge as that read raises no overrun.
- R9: An active-low reset clears `intReq`, `overrun`, the holding register and the result register.
- R10: `intAck` with no pending request drives nothing onto the bus.
- R11: If `intAck` (with a request pending) and a read of 0x8000 share a cycle, the vector wins the bus, and that read neither drops the request nor clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Capture strobe for new input data |
| inData | input | DW (8) | Input data word |
| busAddr | input | AW (16) | Processor bus address |
| busRd | input | 1 | Processor read strobe |
| busWr | input | 1 | Processor write strobe |
| busWrData | input | DW (8) | Processor write data |
| intAck | input | 1 | Interrupt acknowledge strobe from the processor |
| tableMode | input | 1 | 0: drive full vector on acknowledge, 1: drive table index |
| busDout | output | DW (8) | Read-data bus contribution, zero when not driving |
| busDoutEn | output | 1 | Output enable for `busDout` |
| intReq | output | 1 | Interrupt request to the processor |
| overrun | output | 1 | Sticky flag: data was overwritten while a request was pending |
| resultData | output | DW (8) | Current value of the result register |

## Verification
The bench targets the edges where request and overrun state meet bus traffic. These are a capture and a read at the same edge, a second capture before any read, an acknowledge that overlaps a data read, and an acknowledge with nothing pending. A design that got these wrong would, in turn, lose a request or flag a false overrun, keep stale data, consume the data during a vector cycle, or drive the bus with no request behind it. Writes to the read-only holding register and to unmapped addresses are followed by read-backs that would show any corruption. Both vector modes are exercised, so a swapped or truncated index would show on the bus.

// File: rtl/vip_pkg.sv
package vip_pkg;
  // Strobes from control to datapath; at most one sel* is high per cycle.
  typedef struct packed {
    logic loadIn;   // capture inData into holding register
    logic loadRes;  // write busWrData into result register
    logic selVec;   // drive full vector
    logic selIdx;   // drive table index
    logic selIn;    // drive holding register
    logic selRes;   // drive result register
  } vipStrobes_t;
endpackage

// File: rtl/vip_ctrl.sv
module vip_ctrl
  import vip_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] IN_ADDR  = 16'h8000,
  parameter logic [AW-1:0] RES_ADDR = 16'h8001
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [AW-1:0] busAddr,
  input  logic          busRd,
  input  logic          busWr,
  input  logic          intAck,
  input  logic          tableMode,
  output logic          intReq,
  output logic          overrun,
  output logic          busDoutEn,
  output vipStrobes_t   strb
);
  logic reqQ, ovQ;
  logic ackHit, rdIn, rdRes, wrRes;
  logic reqNext, ovNext;

  assign ackHit = intAck && reqQ;
  assign rdIn   = busRd && (busAddr == IN_ADDR) && !ackHit;
  assign rdRes  = busRd && (busAddr == RES_ADDR) && !ackHit;
  assign wrRes  = busWr && (busAddr == RES_ADDR);

  always_comb begin
    reqNext = reqQ;
    ovNext  = ovQ;
    if (rdIn) begin
      reqNext = 1'b0;
      ovNext  = 1'b0;
    end
    if (inValid) begin
      reqNext = 1'b1;
      if (reqQ && !rdIn) ovNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      ovQ  <= 1'b0;
    end else begin
      reqQ <= reqNext;
      ovQ  <= ovNext;
    end
  end

  assign intReq       = reqQ;
  assign overrun      = ovQ;
  assign busDoutEn    = ackHit || rdIn || rdRes;
  assign strb.loadIn  = inValid;
  assign strb.loadRes = wrRes;
  assign strb.selVec  = ackHit && !tableMode;
  assign strb.selIdx  = ackHit && tableMode;
  assign strb.selIn   = rdIn;
  assign strb.selRes  = rdRes;

  assert_req_after_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> intReq);
  assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !(busRd && busAddr == IN_ADDR)) |=> intReq);
  assert_req_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == IN_ADDR && !intAck && !inValid) |=> !intReq);
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && intReq && !busRd) |=> overrun);
  assert_ack_keeps_R11: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq && overrun) |=> (intReq && overrun));
endmodule

// File: rtl/vip_datapath.sv
module vip_datapath
  import vip_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 8,
  parameter logic [DW-1:0] FULL_VECTOR = 16,
  parameter logic [IW-1:0] TABLE_INDEX = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  vipStrobes_t   strb,
  input  logic [DW-1:0] inData,
  input  logic [DW-1:0] busWrData,
  output logic [DW-1:0] busDout,
  output logic [DW-1:0] resultData
);
  localparam logic [DW-1:0] IDX_EXT = DW'(TABLE_INDEX);

  logic [DW-1:0] holdQ, resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= '0;
      resQ  <= '0;
    end else begin
      if (strb.loadIn)  holdQ <= inData;
      if (strb.loadRes) resQ  <= busWrData;
    end
  end

  always_comb begin
    if (strb.selVec)      busDout = FULL_VECTOR;
    else if (strb.selIdx) busDout = IDX_EXT;
    else if (strb.selIn)  busDout = holdQ;
    else if (strb.selRes) busDout = resQ;
    else                  busDout = '0;
  end

  assign resultData = resQ;

  assert_one_sel_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selVec, strb.selIdx, strb.selIn, strb.selRes}));
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadIn |=> $stable(holdQ));
endmodule

// File: rtl/vec_irq_periph.sv
module vec_irq_periph
  import vip_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int IW = 8,
  parameter logic [AW-1:0] IN_ADDR     = 16'h8000,
  parameter logic [AW-1:0] RES_ADDR    = 16'h8001,
  parameter logic [DW-1:0] FULL_VECTOR = 16,
  parameter logic [IW-1:0] TABLE_INDEX = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  input  logic [AW-1:0] busAddr,
  input  logic          busRd,
  input  logic          busWr,
  input  logic [DW-1:0] busWrData,
  input  logic          intAck,
  input  logic          tableMode,
  output logic [DW-1:0] busDout,
  output logic          busDoutEn,
  output logic          intReq,
  output logic          overrun,
  output logic [DW-1:0] resultData
);
  vipStrobes_t strb;

  vip_ctrl #(.AW(AW), .IN_ADDR(IN_ADDR), .RES_ADDR(RES_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .intAck(intAck), .tableMode(tableMode),
    .intReq(intReq), .overrun(overrun), .busDoutEn(busDoutEn), .strb(strb)
  );

  vip_datapath #(.DW(DW), .IW(IW), .FULL_VECTOR(FULL_VECTOR),
                 .TABLE_INDEX(TABLE_INDEX)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .busWrData(busWrData), .busDout(busDout), .resultData(resultData)
  );

  assert_vector_R2: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq && !tableMode) |-> (busDoutEn && busDout == FULL_VECTOR));
  assert_index_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq && tableMode) |-> (busDoutEn && busDout == DW'(TABLE_INDEX)));
  assert_bus_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busDoutEn |-> (busDout == '0));
  assert_no_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busRd && !(intAck && intReq)) |-> !busDoutEn);
endmodule

// File: tb/tb_vec_irq_periph.sv
`timescale 1ns/1ps
module tb_vec_irq_periph;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] A_IN  = 16'h8000;
  localparam logic [AW-1:0] A_RES = 16'h8001;
  localparam int VEC = 16;
  localparam int IDX = 3;

  logic clk = 0, rstN = 0;
  logic inValid = 0, busRd = 0, busWr = 0, intAck = 0, tableMode = 0;
  logic [DW-1:0] inData = 0, busWrData = 0;
  logic [AW-1:0] busAddr = 0;
  logic [DW-1:0] busDout, resultData;
  logic busDoutEn, intReq, overrun;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  // behavioural reference state
  int mHold = 0, mRes = 0;
  bit mReq = 0, mOv = 0;

  always #2.5 clk = ~clk;

  vec_irq_periph dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWrData(busWrData),
    .intAck(intAck), .tableMode(tableMode), .busDout(busDout),
    .busDoutEn(busDoutEn), .intReq(intReq), .overrun(overrun),
    .resultData(resultData)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare outputs against the model, then advance model over one rising edge
  task automatic step(input string tag);
    bit ack, rdIn, rdRes, expEn;
    int expDout;
    bit nReq, nOv;
    #1;
    ack = intAck && mReq;
    rdIn  = busRd && busAddr == A_IN && !ack;
    rdRes = busRd && busAddr == A_RES && !ack;
    expEn = ack || rdIn || rdRes;
    if (ack) expDout = tableMode ? IDX : VEC;
    else if (rdIn) expDout = mHold;
    else if (rdRes) expDout = mRes;
    else expDout = 0;
    chk(tag, "busDoutEn", busDoutEn, expEn);
    chk(tag, "busDout", busDout, expDout);
    chk(tag, "intReq", intReq, mReq);
    chk(tag, "overrun", overrun, mOv);
    chk(tag, "resultData", resultData, mRes);
    @(posedge clk);
    nReq = mReq; nOv = mOv;
    if (rdIn) begin nReq = 0; nOv = 0; end
    if (inValid) begin
      nReq = 1;
      if (mReq && !rdIn) nOv = 1;
      mHold = inData;
    end
    if (busWr && busAddr == A_RES) mRes = busWrData;
    mReq = nReq; mOv = nOv;
    @(negedge clk);
    inValid = 0; busRd = 0; busWr = 0; intAck = 0;
  endtask

  task automatic doReset(input string tag);
    rstN = 0;
    mHold = 0; mRes = 0; mReq = 0; mOv = 0;
    @(posedge clk); @(negedge clk);
    step(tag);
    rstN = 1;
  endtask

  task automatic cap(input int d); inValid = 1; inData = DW'(d); endtask
  task automatic rd(input logic [AW-1:0] a); busRd = 1; busAddr = a; endtask
  task automatic wr(input logic [AW-1:0] a, input int d);
    busWr = 1; busAddr = a; busWrData = DW'(d);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset("R9 reset state");
    step("R9 idle");
    intAck = 1; step("R10 ack with no request");
    cap(8'hA5); step("R1 capture");
    step("R1 request raised");
    intAck = 1; step("R2 full vector");
    step("R3 request held after ack");
    wr(A_IN, 8'hFF); step("R4 write to holding ignored");
    rd(A_IN); step("R4 read holding");
    step("R3 request dropped after read");
    wr(A_RES, 8'h5A); step("R5 write result");
    rd(A_RES); step("R5 read result");
    tableMode = 1;
    cap(8'h33); step("R6 capture");
    intAck = 1; step("R6 table index");
    rd(A_IN); step("R6 read");
    tableMode = 0;
    cap(8'h11); step("R8 first capture");
    cap(8'h22); step("R8 second capture");
    rd(A_IN); step("R8 newest data kept");
    step("R8 overrun cleared");
    cap(8'h44); step("R8 capture");
    cap(8'h55); rd(A_IN); step("R8 capture with read");
    step("R8 no overrun, request kept");
    cap(8'h66); step("R11 overrun setup");
    intAck = 1; rd(A_IN); step("R11 ack beats read");
    step("R11 request and overrun kept");
    rd(A_IN); step("R11 real read");
    wr(16'h1234, 8'h99); step("R7 unmapped write");
    rd(16'h1234); step("R7 unmapped read");
    rd(A_RES); step("R7 result unchanged");
    rd(A_IN); step("R7 holding unchanged");
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 0) cap(i * 7 + 1);
      if (i % 4 == 1) rd(A_IN);
      if (i % 5 == 2) intAck = 1;
      if (i % 6 == 3) wr(A_RES, i);
      tableMode = (i % 2 == 0);
      step("R3 mixed traffic");
    end
    tableMode = 0;
    cap(8'h77); step("R9 setup");
    wr(A_RES, 8'h12); step("R9 setup");
    doReset("R9 reset mid-run");
    step("R9 after reset");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule